// File: doc/BRIEF.md
# Transport-Controlled Audio Sample Fetcher

This block walks through an 8-bit audio waveform kept in a 32-bit wide memory and hands the samples, one at a time, to a downstream pulse-width modulation stage. Each word holds four samples. A free-running tick divider sets the sample rate. On every tick the block may issue one read and pick one byte from the word that comes back. That byte is then presented together with a one-cycle ready pulse.

A 3-bit transport command, qualified by a valid strobe, controls where playback goes. The commands are normal play, pause, stop, fast-forward on and off, and rewind on and off. A command is held until the next tick and takes effect there. The memory port is a plain synchronous read: the block drives an address and a read enable, and the data word is expected one cycle later.

Top module: `audio_transport_ctrl`

## Requirements
- R1: After reset the block is stopped at sample position 0, `sample_o` is 0 and `sample_ready_o` is low.
- R2: A tick occurs once every `TICK_DIV` cycles, the first one `TICK_DIV` cycles after reset. A tick that plays a sample drives `mem_rd_o` in that cycle, and `sample_ready_o` rises for exactly one cycle two cycles later.
- R3: During normal play (command 0) consecutive ticks deliver consecutive samples. Within a word, byte 0 (bits 7:0) comes first and byte 3 (bits 31:24) last, then the word address increments.
- R4: Pause (command 1) produces no ready pulses and keeps the position. A later play resumes with the sample that would have come next.
- R5: Stop (command 2) moves the position to word 0, byte 0 and produces no ready pulses until a play command. That play then delivers sample 0 first.
- R6: Fast-forward on (command 3) delivers the sample at the current position and then advances the position by 4 samples per tick.
- R7: Rewind on (command 5) delivers the sample at the current position and then moves back by 4 samples per tick, stopping at position 0 and not going below it.
- R8: Fast-forward off (command 4) and rewind off (command 6) return to normal play, one sample per tick, from the position already reached.
- R9: Moving forward past the last stored sample (word `LAST_ADDR`, byte 3) continues at position 0. The block never reads above `LAST_ADDR`.
- R10: Command 7 is ignored. A valid command is applied at the next tick, and a later valid command before that tick replaces an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Transport command code |
| op_valid_i | input | 1 | Qualifies `op_i` for one cycle |
| mem_addr_o | output | ADDR_W | Word address for the read |
| mem_rd_o | output | 1 | Read enable; data expected one cycle later |
| mem_rdata_i | input | WORD_W | Word returned by the memory |
| sample_o | output | SAMPLE_W | Current sample for the PWM stage |
| sample_ready_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
The memory is filled with distinct random bytes, so every delivered sample identifies its own position. Long play runs cross byte and word boundaries and the wrap point, which shows whether the byte order and the address increment are right. Fast-forward and rewind runs show the 4-sample step and the floor at zero. Pause and stop sequences followed by play show whether the held position is kept or cleared. Bursts of random commands, including code 7 and several commands between two ticks, check that the last valid command wins and that the ignored code changes nothing.

// File: rtl/atc_pkg.sv
package atc_pkg;

    typedef enum logic [2:0] {
        OP_PLAY   = 3'd0,
        OP_PAUSE  = 3'd1,
        OP_STOP   = 3'd2,
        OP_FF_ON  = 3'd3,
        OP_FF_OFF = 3'd4,
        OP_RW_ON  = 3'd5,
        OP_RW_OFF = 3'd6,
        OP_NONE   = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        M_STOPPED,
        M_PLAY,
        M_PAUSED,
        M_FFWD,
        M_REWIND
    } mode_e;

    function automatic mode_e apply_op(mode_e cur, op_e op);
        case (op)
            OP_PLAY, OP_FF_OFF, OP_RW_OFF: return M_PLAY;
            OP_PAUSE:                      return M_PAUSED;
            OP_STOP:                       return M_STOPPED;
            OP_FF_ON:                      return M_FFWD;
            OP_RW_ON:                      return M_REWIND;
            default:                       return cur;
        endcase
    endfunction

    function automatic logic is_active(mode_e m);
        return (m == M_PLAY) || (m == M_FFWD) || (m == M_REWIND);
    endfunction

endpackage

// File: rtl/atc_tick.sv
module atc_tick #(
    parameter int TICK_DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/atc_step.sv
module atc_step
    import atc_pkg::*;
#(
    parameter int POS_W    = 20,
    parameter int LAST_POS = 1048575
) (
    input  logic [POS_W-1:0] pos_i,
    input  mode_e            mode_i,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W:0] LASTW = (POS_W+1)'(LAST_POS);

    logic [POS_W:0] fwd;

    always_comb begin
        fwd   = {1'b0, pos_i} + ((mode_i == M_FFWD) ? (POS_W+1)'(4) : (POS_W+1)'(1));
        pos_o = pos_i;
        case (mode_i)
            M_PLAY, M_FFWD: pos_o = (fwd > LASTW) ? '0 : fwd[POS_W-1:0];
            M_REWIND:       pos_o = (pos_i < POS_W'(4)) ? '0 : pos_i - POS_W'(4);
            default:        pos_o = pos_i;
        endcase
    end
endmodule

// File: rtl/audio_transport_ctrl.sv
module audio_transport_ctrl
    import atc_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int WORD_W    = 32,
    parameter int SAMPLE_W  = 8,
    parameter int TICK_DIV  = 1024,
    parameter int LAST_ADDR = (1 << 18) - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          op_i,
    input  logic                op_valid_i,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic                mem_rd_o,
    input  logic [WORD_W-1:0]   mem_rdata_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                sample_ready_o
);
    localparam int PER_WORD = WORD_W / SAMPLE_W;
    localparam int IDX_W    = $clog2(PER_WORD);
    localparam int POS_W    = ADDR_W + IDX_W;
    localparam int LAST_POS = (LAST_ADDR + 1) * PER_WORD - 1;

    typedef struct packed {
        mode_e               mode;
        op_e                 pend;
        logic [POS_W-1:0]    pos;
        logic                fetch;
        logic [IDX_W-1:0]    fidx;
        logic [SAMPLE_W-1:0] sample;
        logic                ready;
    } state_t;

    state_t s_d, s_q;

    logic             tick;
    op_e              cur_op;
    mode_e            mode_next;
    logic [POS_W-1:0] pos_base, pos_step;

    atc_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    // Command and mode seen at the tick: a command in the tick cycle wins.
    always_comb begin
        cur_op    = (op_valid_i && op_i != 3'(OP_NONE)) ? op_e'(op_i) : s_q.pend;
        mode_next = apply_op(s_q.mode, cur_op);
        pos_base  = (mode_next == M_STOPPED) ? '0 : s_q.pos;
    end

    atc_step #(.POS_W(POS_W), .LAST_POS(LAST_POS)) u_step (
        .pos_i (pos_base),
        .mode_i(mode_next),
        .pos_o (pos_step)
    );

    always_comb begin
        s_d       = s_q;
        s_d.ready = 1'b0;
        s_d.fetch = 1'b0;
        mem_rd_o  = 1'b0;
        mem_addr_o = s_q.pos[POS_W-1:IDX_W];
        if (tick) begin
            s_d.pend = OP_NONE;
            s_d.mode = mode_next;
            s_d.pos  = pos_base;
            if (is_active(mode_next)) begin
                mem_rd_o   = 1'b1;
                mem_addr_o = pos_base[POS_W-1:IDX_W];
                s_d.fetch  = 1'b1;
                s_d.fidx   = pos_base[IDX_W-1:0];
                s_d.pos    = pos_step;
            end
        end else if (op_valid_i && op_i != 3'(OP_NONE)) begin
            s_d.pend = op_e'(op_i);
        end
        if (s_q.fetch) begin
            s_d.sample = mem_rdata_i[s_q.fidx*SAMPLE_W +: SAMPLE_W];
            s_d.ready  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode   <= M_STOPPED;
            s_q.pend   <= OP_NONE;
            s_q.pos    <= '0;
            s_q.fetch  <= 1'b0;
            s_q.fidx   <= '0;
            s_q.sample <= '0;
            s_q.ready  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sample_o       = s_q.sample;
    assign sample_ready_o = s_q.ready;
endmodule

// File: rtl/atc_checks.sv
module atc_checks #(
    parameter int ADDR_W    = 18,
    parameter int SAMPLE_W  = 8,
    parameter int TICK_DIV  = 1024,
    parameter int LAST_ADDR = (1 << 18) - 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   mem_addr_o,
    input logic                mem_rd_o,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                sample_ready_o
);
    logic [31:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (mem_rd_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 32'hFFFF_FFFF) begin
            gap_q <= gap_q + 1;
        end
    end

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ready_o |=> !sample_ready_o); // R2

    AST_READY_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ready_o |-> $past(mem_rd_o, 2)); // R2

    AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && seen_q) |-> (gap_q >= 32'(TICK_DIV - 1))); // R2

    AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_ready_o |-> $stable(sample_o)); // R3

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> (32'(mem_addr_o) <= 32'(LAST_ADDR))); // R9
endmodule

bind audio_transport_ctrl atc_checks #(
    .ADDR_W   (ADDR_W),
    .SAMPLE_W (SAMPLE_W),
    .TICK_DIV (TICK_DIV),
    .LAST_ADDR(LAST_ADDR)
) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_addr_o    (mem_addr_o),
    .mem_rd_o      (mem_rd_o),
    .sample_o      (sample_o),
    .sample_ready_o(sample_ready_o)
);

// File: tb/audio_transport_ctrl_test.sv
`timescale 1ns/1ps
module audio_transport_ctrl_test;
    localparam int ADDR_W = 18, WORD_W = 32, SAMPLE_W = 8;
    localparam int DIV = 8, LAST_ADDR = 15;
    localparam int NPOS = (LAST_ADDR + 1) * 4;

    logic clk = 0, rst_n = 0;
    logic [2:0] op_i = 0;
    logic op_valid_i = 0;
    logic [ADDR_W-1:0] mem_addr_o;
    logic mem_rd_o;
    logic [WORD_W-1:0] mem_rdata_i;
    logic [SAMPLE_W-1:0] sample_o;
    logic sample_ready_o;

    always #4 clk = ~clk;

    audio_transport_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W),
        .TICK_DIV(DIV), .LAST_ADDR(LAST_ADDR)) uut (.*);

    logic [WORD_W-1:0] mem [0:LAST_ADDR];
    always_ff @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[3:0]];

    int checks = 0, fails = 0, cyc = 0;
    string tag = "R1";
    // model: 0 stopped,1 play,2 paused,3 ffwd,4 rewind
    int m_mode = 0, m_pos = 0, m_pend = 7, exp_at = -1;
    logic [7:0] exp_val = 0;
    bit done = 0;

    function automatic logic [7:0] byte_at(int p);
        logic [31:0] w = mem[p / 4];
        return w[(p % 4) * 8 +: 8];
    endfunction

    function automatic int next_mode(int m, int op);
        case (op)
            0, 4, 6: return 1;
            1: return 2;
            2: return 0;
            3: return 3;
            5: return 4;
            default: return m;
        endcase
    endfunction

    task automatic model_tick();
        m_mode = next_mode(m_mode, m_pend);
        m_pend = 7;
        if (m_mode == 0) m_pos = 0;
        if (m_mode == 1 || m_mode == 3 || m_mode == 4) begin
            exp_at  = cyc + 2;
            exp_val = byte_at(m_pos);
            if (m_mode == 1) m_pos = (m_pos + 1 > NPOS - 1) ? 0 : m_pos + 1;
            else if (m_mode == 3) m_pos = (m_pos + 4 > NPOS - 1) ? 0 : m_pos + 4;
            else m_pos = (m_pos < 4) ? 0 : m_pos - 4;
        end
    endtask

    task automatic check(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic step();
        if (cyc % DIV == DIV - 1) model_tick();
        @(posedge clk); #2; cyc++;
        check(sample_ready_o == (exp_at == cyc), "ready", sample_ready_o, exp_at == cyc);
        if (exp_at == cyc)
            check(sample_o == exp_val, "sample", sample_o, exp_val);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic send(int op);
        op_i = 3'(op); op_valid_i = 1;
        if (op != 7) m_pend = op;
        step();
        op_valid_i = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i <= LAST_ADDR; i++) mem[i] = $urandom;
        repeat (3) @(posedge clk);
        #2; rst_n = 1; cyc = 0;
        tag = "R1";
        check(sample_o == 0, "reset sample", sample_o, 0);
        check(sample_ready_o == 0, "reset ready", sample_ready_o, 0);
        run(5 * DIV);                          // stopped: no pulses
        tag = "R3"; send(0); run(30 * DIV);    // play across words
        tag = "R9"; run(50 * DIV);             // wrap past last sample
        tag = "R4"; send(1); run(10 * DIV); send(0); run(6 * DIV);
        tag = "R6"; send(3); run(20 * DIV);
        tag = "R8"; send(4); run(6 * DIV);
        tag = "R7"; send(5); run(25 * DIV);    // hits floor at 0
        tag = "R8"; send(6); run(6 * DIV);
        tag = "R10"; send(7); run(4 * DIV); send(1); send(7); run(3 * DIV);
        send(3); run(2); send(0); run(4 * DIV);
        tag = "R5"; send(2); run(8 * DIV); send(0); run(6 * DIV);
        tag = "R2";
        for (int k = 0; k < 400; k++) begin
            send($urandom_range(0, 7));
            run($urandom_range(0, 3 * DIV));
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule